// File: doc/BRIEF.md
# Instanced Attribute Index Generator

This block turns the linear index of a dispatched thread into the index of the attribute element that the thread should fetch. A request carries a two-bit mode code. Pass-through gives the index back unchanged, for draws without instancing. Modulo mode wraps the index by a padded vertex count of the form (odd factor)·2^shift. Shift mode divides by a power of two. Magic mode divides by an arbitrary constant using a precomputed 32-bit reciprocal multiplier. In that mode an optional round-down correction is applied and a final right shift follows.

A request is presented with `inValid` together with its index and constants. The result appears on `elemIdx` with `outValid` exactly two clock cycles later, and a new request may be accepted in every cycle. Between results the output keeps the last value it delivered. Address arithmetic from a base and stride, and the derivation of the constants, are left to the neighbouring logic.

Top module: `attr_index_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the first result, `outValid` is 0 and `elemIdx` is 0.
- R2: Each cycle with `inValid` high yields exactly one cycle of `outValid` two clock edges later, in order, including back-to-back requests; no other cycle has `outValid` high.
- R3: Mode code 0 (pass-through) returns `linearIdx` unchanged.
- R4: Mode code 1 (modulo) with `extraFlags` in 0..4 returns `linearIdx` mod ((2·extraFlags+1)·2^shiftAmt), so the low `shiftAmt` bits of the index pass through unchanged.
- R5: Mode code 1 with `extraFlags` in 5..7 uses an odd factor of 1, returning `linearIdx` mod 2^shiftAmt.
- R6: Mode code 2 (power-of-two divide) returns `linearIdx` shifted right by `shiftAmt`.
- R7: Mode code 3 (magic divide) forms the multiplier as `magicMul` with bit 31 forced to 1, takes bits 63:32 of the 64-bit product with the index, and shifts that right by `shiftAmt`; with `extraFlags` other than 1 no correction is applied.
- R8: In mode code 3 with `extraFlags` equal to 1, the multiplicand is `linearIdx`+1, saturating at 0xFFFFFFFF when the index is already all ones.
- R9: In a cycle where `outValid` is low, `elemIdx` holds the last delivered result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| linearIdx | input | 32 | Linear thread index |
| modeSel | input | 2 | Mode code: 0 pass, 1 modulo, 2 shift divide, 3 magic divide |
| shiftAmt | input | 5 | Power-of-two exponent or post-shift |
| extraFlags | input | 3 | Odd-factor code (modulo) or round-down flag (magic) |
| magicMul | input | 32 | Reciprocal multiplier; bit 31 is ignored and treated as 1 |
| outValid | output | 1 | Result strobe |
| elemIdx | output | 32 | Attribute element index |

## Verification
The hardest case to reach is the saturating round-down: it needs magic mode, flag value 1 and an index of all ones all at once. It also needs a multiplier whose stored top bit is 0, so that a missing forced bit shows up in the result. Directed requests create this combination. They also cover multiplier zero, each odd modulo factor at shift 0 and shift 31, and an all-ones index. After these, a long stream of random requests with random bubbles runs on every mode code, so that back-to-back results and held outputs are compared in every cycle against a behavioural model.

// File: rtl/attr_idx_pkg.sv
package attr_idx_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_MOD   = 2'd1,
    MODE_SHR   = 2'd2,
    MODE_MAGIC = 2'd3
  } idxMode_t;

  typedef struct packed {
    logic loadStage;
    logic loadResult;
  } idxStrobe_t;
endpackage

// File: rtl/attr_idx_ctrl.sv
module attr_idx_ctrl
  import attr_idx_pkg::*;
#(
  parameter bit TWO_STAGE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output idxStrobe_t strobe,
  output logic       outValid
);
  generate
    if (TWO_STAGE) begin : gTwo
      logic stgValid;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stgValid <= 1'b0;
          outValid <= 1'b0;
        end else begin
          stgValid <= inValid;
          outValid <= stgValid;
        end
      end
      always_comb begin
        strobe.loadStage  = inValid;
        strobe.loadResult = stgValid;
      end
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        outValid == $past(inValid, 2)); // R2
    end else begin : gOne
      always_ff @(posedge clk) begin
        if (!rst_n) outValid <= 1'b0;
        else        outValid <= inValid;
      end
      always_comb begin
        strobe.loadStage  = inValid;
        strobe.loadResult = inValid;
      end
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        outValid == $past(inValid)); // R2
    end
  endgenerate
endmodule

// File: rtl/attr_idx_dpath.sv
module attr_idx_dpath
  import attr_idx_pkg::*;
#(
  parameter int IDX_W     = 32,
  parameter int SHIFT_W   = 5,
  parameter int FLAG_W    = 3,
  parameter bit TWO_STAGE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  idxStrobe_t         strobe,
  input  logic [IDX_W-1:0]   linearIdx,
  input  logic [1:0]         modeSel,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic [FLAG_W-1:0]  extraFlags,
  input  logic [IDX_W-1:0]   magicMul,
  output logic [IDX_W-1:0]   elemIdx
);
  localparam int PROD_W = 2 * IDX_W;
  localparam logic [FLAG_W-1:0] ROUND_CODE = FLAG_W'(1);
  localparam logic [IDX_W-1:0]  TOP_BIT = IDX_W'(1) << (IDX_W - 1);

  logic [IDX_W-1:0]   sIdx, sMagic;
  logic [1:0]         sMode;
  logic [SHIFT_W-1:0] sShift;
  logic [FLAG_W-1:0]  sFlags;

  generate
    if (TWO_STAGE) begin : gStage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sIdx <= '0; sMagic <= '0; sMode <= '0; sShift <= '0; sFlags <= '0;
        end else if (strobe.loadStage) begin
          sIdx <= linearIdx; sMagic <= magicMul; sMode <= modeSel;
          sShift <= shiftAmt; sFlags <= extraFlags;
        end
      end
    end else begin : gDirect
      always_comb begin
        sIdx = linearIdx; sMagic = magicMul; sMode = modeSel;
        sShift = shiftAmt; sFlags = extraFlags;
      end
    end
  endgenerate

  // modulo: high part reduced by the small odd factor, low bits kept
  logic [IDX_W-1:0] hiPart, loPart, hiMod, modRes, shrRes;
  always_comb begin
    hiPart = sIdx >> sShift;
    loPart = sIdx & ~({IDX_W{1'b1}} << sShift);
    case (sFlags)
      FLAG_W'(1): hiMod = hiPart % IDX_W'(3);
      FLAG_W'(2): hiMod = hiPart % IDX_W'(5);
      FLAG_W'(3): hiMod = hiPart % IDX_W'(7);
      FLAG_W'(4): hiMod = hiPart % IDX_W'(9);
      default:    hiMod = '0;
    endcase
    modRes = (hiMod << sShift) | loPart;
    shrRes = sIdx >> sShift;
  end

  // magic divide: forced top bit, optional saturating increment, no pre-shift
  logic [IDX_W-1:0]  mulMag, mulIn, magicRes;
  logic [PROD_W-1:0] product;
  always_comb begin
    mulMag   = sMagic | TOP_BIT;
    mulIn    = (sFlags == ROUND_CODE && sIdx != {IDX_W{1'b1}}) ? sIdx + IDX_W'(1) : sIdx;
    product  = {{IDX_W{1'b0}}, mulIn} * {{IDX_W{1'b0}}, mulMag};
    magicRes = product[PROD_W-1:IDX_W] >> sShift;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) elemIdx <= '0;
    else if (strobe.loadResult) begin
      case (idxMode_t'(sMode))
        MODE_PASS:  elemIdx <= sIdx;
        MODE_MOD:   elemIdx <= modRes;
        MODE_SHR:   elemIdx <= shrRes;
        MODE_MAGIC: elemIdx <= magicRes;
        default:    elemIdx <= sIdx;
      endcase
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadResult |=> $stable(elemIdx)); // R9
endmodule

// File: rtl/attr_index_gen.sv
module attr_index_gen
  import attr_idx_pkg::*;
#(
  parameter int IDX_W     = 32,
  parameter int SHIFT_W   = 5,
  parameter int FLAG_W    = 3,
  parameter bit TWO_STAGE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [IDX_W-1:0]   linearIdx,
  input  logic [1:0]         modeSel,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic [FLAG_W-1:0]  extraFlags,
  input  logic [IDX_W-1:0]   magicMul,
  output logic               outValid,
  output logic [IDX_W-1:0]   elemIdx
);
  localparam int LAT = TWO_STAGE ? 2 : 1;

  idxStrobe_t strobe;

  attr_idx_ctrl #(.TWO_STAGE(TWO_STAGE)) uCtrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  attr_idx_dpath #(.IDX_W(IDX_W), .SHIFT_W(SHIFT_W), .FLAG_W(FLAG_W),
                   .TWO_STAGE(TWO_STAGE)) uDpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .linearIdx(linearIdx), .modeSel(modeSel), .shiftAmt(shiftAmt),
    .extraFlags(extraFlags), .magicMul(magicMul), .elemIdx(elemIdx)
  );

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && $past(modeSel, LAT) == 2'd0 |-> elemIdx == $past(linearIdx, LAT)); // R3
  AST_MOD_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && $past(modeSel, LAT) == 2'd1 |->
      ((elemIdx ^ $past(linearIdx, LAT)) & ~({IDX_W{1'b1}} << $past(shiftAmt, LAT))) == '0); // R4
  AST_SHIFT_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && $past(modeSel, LAT) == 2'd2 |->
      elemIdx == ($past(linearIdx, LAT) >> $past(shiftAmt, LAT))); // R6
  AST_MAGIC_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && $past(modeSel, LAT) == 2'd3 |-> elemIdx <= $past(linearIdx, LAT)); // R7
  AST_MAGIC_TOPBIT: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && $past(modeSel, LAT) == 2'd3 && $past(shiftAmt, LAT) == '0 |->
      elemIdx >= ($past(linearIdx, LAT) >> 1)); // R7
endmodule

// File: tb/tb_attr_index_gen.sv
module tb_attr_index_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] linearIdx = '0;
  logic [1:0]  modeSel = '0;
  logic [4:0]  shiftAmt = '0;
  logic [2:0]  extraFlags = '0;
  logic [31:0] magicMul = '0;
  logic        outValid;
  logic [31:0] elemIdx;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  attr_index_gen dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .linearIdx(linearIdx),
    .modeSel(modeSel), .shiftAmt(shiftAmt), .extraFlags(extraFlags),
    .magicMul(magicMul), .outValid(outValid), .elemIdx(elemIdx)
  );

  // behavioural model: two in-flight slots and the held output
  bit          lastV, midV, expV;
  logic [31:0] lastD, midD, expD;
  string       lastTag, midTag, expTag;

  function automatic logic [31:0] refIdx(logic [31:0] idx, int mode, int sh, int ef,
                                         logic [31:0] mag);
    longint unsigned x, m, modulus;
    case (mode)
      0: return idx;
      1: begin
        modulus = longint'((ef <= 4) ? 2 * ef + 1 : 1) << sh;
        return 32'(longint'(idx) % modulus);
      end
      2: return idx >> sh;
      default: begin
        m = longint'(mag) | 64'h8000_0000;
        x = longint'(idx);
        if (ef == 1 && idx != 32'hFFFF_FFFF) x = x + 1;
        return 32'(((x * m) >> 32) >> sh);
      end
    endcase
  endfunction

  function automatic string tagFor(int mode, int ef);
    case (mode)
      0: return "R3";
      1: return (ef > 4) ? "R5" : "R4";
      2: return "R6";
      default: return (ef == 1) ? "R8" : "R7";
    endcase
  endfunction

  task automatic compareNow();
    checks++;
    if (outValid !== expV) begin
      errors++;
      $display("FAIL R2 outValid actual %0b expected %0b at %0t", outValid, expV, $time);
    end else if (expV && elemIdx !== expD) begin
      errors++;
      $display("FAIL %s elemIdx actual %h expected %h at %0t", expTag, elemIdx, expD, $time);
    end else if (!expV && elemIdx !== expD) begin
      errors++;
      $display("FAIL R9 held elemIdx actual %h expected %h at %0t", elemIdx, expD, $time);
    end
  endtask

  task automatic step(bit v, logic [31:0] idx, int mode, int sh, int ef, logic [31:0] mag);
    @(negedge clk);
    expV = midV;
    if (midV) begin expD = midD; expTag = midTag; end
    midV = lastV; midD = lastD; midTag = lastTag;
    compareNow();
    inValid = v; linearIdx = idx; modeSel = 2'(mode);
    shiftAmt = 5'(sh); extraFlags = 3'(ef); magicMul = mag;
    lastV = v;
    lastD = refIdx(idx, mode, sh, ef, mag);
    lastTag = tagFor(mode, ef);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    lastV = 0; midV = 0; expV = 0; lastD = '0; midD = '0; expD = '0;
    lastTag = "R1"; midTag = "R1"; expTag = "R1";
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (outValid !== 1'b0 || elemIdx !== 32'h0) begin
        errors++;
        $display("FAIL R1 reset actual %0b/%h expected 0/00000000", outValid, elemIdx);
      end
    end
    rst_n = 1'b1;

    // R3 pass-through
    step(1, 32'h1234_5678, 0, 7, 3, 32'h0);
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 32'h0);
    // R4 each odd factor, several shifts
    for (int ef = 0; ef <= 4; ef++) begin
      step(1, 32'd70, 1, 3, ef, 32'h0);
      step(1, 32'hFFFF_FFFF, 1, 0, ef, 32'h0);
      step(1, 32'hFFFF_FFFF, 1, 31, ef, 32'h0);
      step(1, 32'hDEAD_BEEF, 1, 2, ef, 32'h0);
    end
    // R5 out-of-range odd codes
    for (int ef = 5; ef <= 7; ef++) step(1, 32'hCAFE_F00D, 1, 4, ef, 32'h0);
    // R6 power-of-two divide
    step(1, 32'h8000_0001, 2, 0, 0, 32'h0);
    step(1, 32'h8000_0001, 2, 31, 0, 32'h0);
    step(1, 32'd1000, 2, 3, 2, 32'h0);
    // R7 forced top bit: stored multiplier of zero
    step(1, 32'd1000, 3, 0, 0, 32'h0);
    step(1, 32'hFFFF_FFFF, 3, 0, 0, 32'h0);
    // R8 divide by 3: shift 1, multiplier 0xAAAAAAAA with round-down
    step(1, 32'd299, 3, 1, 1, 32'hAAAA_AAAA);
    step(1, 32'd300, 3, 1, 1, 32'hAAAA_AAAA);
    step(1, 32'hFFFF_FFFF, 3, 1, 1, 32'hAAAA_AAAA);
    step(1, 32'hFFFF_FFFF, 3, 0, 1, 32'h0);
    // R9 bubbles then results resume
    step(0, 32'h5555_5555, 0, 0, 0, 32'h0);
    step(0, 32'h0, 2, 1, 0, 32'h0);
    step(0, 32'h0, 3, 0, 1, 32'h0);
    // random mix, every mode, random gaps
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, $urandom, $urandom % 4, $urandom % 32, $urandom % 8,
           $urandom);
    end
    for (int i = 0; i < 4; i++) step(0, 32'h0, 0, 0, 0, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule